// File: doc/BRIEF.md
# Scrambled SLIP Frame Encoder

This block turns a stream of payload bytes, grouped into packets by a last-byte flag, into a byte stream that a receiver can cut back into packets even after it joins mid-stream or loses bytes. Every packet ends with a delimiter byte. A delimiter value or escape value that falls inside the payload is replaced by a two-byte escape pair, so the delimiter never appears inside a frame.

Before the escape check, each payload byte is XORed with a keystream byte. A 16-bit LFSR produces the keystream. The generator returns to a fixed seed each time a delimiter is sent, so both ends agree on the keystream at every frame boundary. Payloads that repeat one value many times, which are common when sampling an idle bus, are therefore spread over the byte space. Such a run no longer doubles the frame, although the worst case stays bounded. Input and output both use valid/ready handshakes. The output is a single registered byte slot, which suits a parallel FIFO link that can stall.

Top module: `frame_enc`

## Requirements
- R1: While reset is active, and on the first cycle after it, outValid is low and inReady is high. The keystream is back at its seed 0xACE1.
- R2: The keystream byte is the low byte of a 16-bit Fibonacci LFSR. After each payload byte the LFSR steps 8 times: feedback = s[0]^s[2]^s[3]^s[5] is shifted in at bit 15. The first byte of a frame is therefore XORed with 0xE1.
- R3: When a scrambled byte equals the delimiter 0xC0, the output is 0xDB followed by 0xDC.
- R4: When a scrambled byte equals the escape 0xDB, the output is 0xDB followed by 0xDD.
- R5: Any other scrambled byte is output as a single byte, unchanged.
- R6: After the byte flagged last, including its escape pair if it has one, exactly one 0xC0 is output. The keystream then restarts from the seed for the next frame.
- R7: inReady is low while the second byte of an escape pair or a delimiter is still waiting to be loaded.
- R8: While outValid is high and outReady is low, outValid stays high and outData does not change.
- R9: An N-byte frame produces at most 2N+1 output bytes. It produces exactly 2N+1 when every scrambled byte needs an escape.
- R10: An escape pair consumes exactly one keystream step. The payload byte that follows an escaped byte is keyed with the next LFSR value in sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload byte offered |
| inData | input | 8 | Payload byte |
| inLast | input | 1 | Offered byte is the last of its packet |
| inReady | output | 1 | Encoder accepts the offered byte this cycle |
| outValid | output | 1 | Encoded byte available |
| outData | output | 8 | Encoded byte |
| outReady | input | 1 | Downstream takes the encoded byte this cycle |

## Verification
The properties assume that the upstream source keeps inValid, inData and inLast steady until the byte is accepted. They also assume that 0xDB on the output is only ever the lead of an escape pair, which holds only if the escape rules are correct. The stimulus drives inputs only at the falling edge and holds each byte until a handshake has been seen. It throttles outReady with a fixed irregular pattern so that stalls land on plain bytes, escape leads and delimiters alike. Payload values that must escape are computed from a keystream model, so R3 and R4 are reached on purpose rather than by chance.

// File: rtl/frame_enc_pkg.sv
package frame_enc_pkg;
  localparam logic [7:0] FRAME_END  = 8'hC0;
  localparam logic [7:0] FRAME_ESC  = 8'hDB;
  localparam logic [7:0] ESC_OF_END = 8'hDC;
  localparam logic [7:0] ESC_OF_ESC = 8'hDD;

  typedef enum logic [1:0] {ST_PASS, ST_TAIL, ST_END} encState_e;

  typedef struct packed {
    logic loadPlain;
    logic loadLead;
    logic loadTail;
    logic loadEnd;
    logic advKey;
    logic seedKey;
    logic dropOut;
  } encStrobe_t;
endpackage

// File: rtl/frame_enc_dp.sv
module frame_enc_dp
  import frame_enc_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h002D
) (
  input  logic       clk,
  input  logic       rstN,
  input  encStrobe_t strb,
  input  logic [7:0] inData,
  output logic       needEsc,
  output logic       outValid,
  output logic [7:0] outData
);
  localparam int BYTE_W = $bits(FRAME_END);
  localparam int STEP_N = BYTE_W;

  logic [LFSR_W-1:0] keyState, keyNext;
  logic [BYTE_W-1:0] scrByte, tailByte;

  // Unrolled multi-step advance: one byte of keystream per clock.
  always_comb begin
    keyNext = keyState;
    for (int k = 0; k < STEP_N; k++) begin
      keyNext = {^(keyNext & LFSR_TAPS), keyNext[LFSR_W-1:1]};
    end
  end

  assign scrByte = inData ^ keyState[BYTE_W-1:0];
  assign needEsc = (scrByte == FRAME_END) || (scrByte == FRAME_ESC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyState <= LFSR_SEED;
      outValid <= 1'b0;
      outData  <= '0;
      tailByte <= '0;
    end else begin
      if (strb.seedKey)     keyState <= LFSR_SEED;
      else if (strb.advKey) keyState <= keyNext;

      if (strb.loadPlain) outData <= scrByte;
      if (strb.loadLead) begin
        outData  <= FRAME_ESC;
        tailByte <= (scrByte == FRAME_END) ? ESC_OF_END : ESC_OF_ESC;
      end
      if (strb.loadTail) outData <= tailByte;
      if (strb.loadEnd)  outData <= FRAME_END;

      if (strb.loadPlain || strb.loadLead || strb.loadTail || strb.loadEnd)
        outValid <= 1'b1;
      else if (strb.dropOut)
        outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_enc_ctrl.sv
module frame_enc_ctrl
  import frame_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       needEsc,
  input  logic       outValid,
  input  logic       outReady,
  output logic       inReady,
  output encStrobe_t strb
);
  encState_e state, stateNext;
  logic lastHeld, lastNext;
  logic slotFree, anyLoad;

  assign slotFree = !outValid || outReady;
  assign inReady  = (state == ST_PASS) && slotFree;

  always_comb begin
    strb      = '0;
    stateNext = state;
    lastNext  = lastHeld;
    unique case (state)
      ST_PASS: if (inValid && slotFree) begin
        if (needEsc) begin
          strb.loadLead = 1'b1;
          lastNext      = inLast;
          stateNext     = ST_TAIL;
        end else begin
          strb.loadPlain = 1'b1;
          strb.advKey    = 1'b1;
          stateNext      = inLast ? ST_END : ST_PASS;
        end
      end
      ST_TAIL: if (slotFree) begin
        strb.loadTail = 1'b1;
        strb.advKey   = 1'b1;
        stateNext     = lastHeld ? ST_END : ST_PASS;
      end
      ST_END: if (slotFree) begin
        strb.loadEnd = 1'b1;
        strb.seedKey = 1'b1;
        stateNext    = ST_PASS;
      end
      default: stateNext = ST_PASS;
    endcase
    anyLoad      = strb.loadPlain || strb.loadLead || strb.loadTail || strb.loadEnd;
    strb.dropOut = outValid && outReady && !anyLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_PASS;
      lastHeld <= 1'b0;
    end else begin
      state    <= stateNext;
      lastHeld <= lastNext;
    end
  end
endmodule

// File: rtl/frame_enc.sv
module frame_enc
  import frame_enc_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h002D
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inLast,
  output logic       inReady,
  output logic       outValid,
  output logic [7:0] outData,
  input  logic       outReady
);
  encStrobe_t strb;
  logic needEsc;

  frame_enc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .needEsc(needEsc), .outValid(outValid), .outReady(outReady),
    .inReady(inReady), .strb(strb)
  );

  frame_enc_dp #(.LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED), .LFSR_TAPS(LFSR_TAPS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .needEsc(needEsc), .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/frame_enc_chk.sv
module frame_enc_chk
  import frame_enc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inLast,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outReady
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && inReady));

  assert_escape_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outData == FRAME_ESC) |=>
      (outValid && (outData == ESC_OF_END || outData == ESC_OF_ESC)));

  assert_end_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);

  assert_hold_input_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outData == FRAME_ESC) |-> !inReady);

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

bind frame_enc frame_enc_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady)
);

// File: tb/frame_enc_tb.sv
module frame_enc_tb;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam int NVEC = 15;
  // {mode[1:0], last, data}: mode 0 raw, 1 force scrambled 0xC0, 2 force scrambled 0xDB
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 8'h00}, {2'd0, 1'b0, 8'h11}, {2'd0, 1'b1, 8'h22},
    {2'd1, 1'b0, 8'h00}, {2'd0, 1'b0, 8'h55}, {2'd2, 1'b0, 8'h00}, {2'd0, 1'b1, 8'hAA},
    {2'd2, 1'b1, 8'h00},
    {2'd1, 1'b0, 8'h00}, {2'd1, 1'b0, 8'h00}, {2'd1, 1'b0, 8'h00}, {2'd1, 1'b1, 8'h00},
    {2'd0, 1'b0, 8'hC0}, {2'd0, 1'b0, 8'hC0}, {2'd0, 1'b1, 8'hDB}
  };

  logic clk = 0, rstN = 0, inValid = 0, inLast = 0, outReady = 0;
  logic [7:0] inData = 0;
  logic inReady, outValid;
  logic [7:0] outData;

  frame_enc u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] mdl = SEED;
  logic [7:0] expByte[$];
  string expTag[$];
  int expLen[$], expN[$];
  int frameLen = 0, frameN = 0, frameCnt = 0;
  bit firstOfFrame = 1, afterEsc = 0, curEsc = 0, chkBlocked = 0, holdPend = 0;
  logic [7:0] holdData;

  function automatic logic [15:0] step8(logic [15:0] s);
    for (int k = 0; k < 8; k++) s = {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    return s;
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic runCycle(output bit accepted);
    outReady = ((cyc % 5) != 3) && ((cyc % 7) != 6);
    cyc++;
    #1;
    if (chkBlocked) begin
      chkBlocked = 0;
      check(inReady == 1'b0, "R7 input held", {7'd0, inReady}, 8'h00);
    end
    if (holdPend) begin
      holdPend = 0;
      check(outValid && outData == holdData, "R8 stall stable", outData, holdData);
    end
    if (outValid && outReady) begin
      if (expByte.size() == 0) check(0, "R5 unexpected byte", outData, 8'hxx);
      else begin
        logic [7:0] e;
        string t;
        e = expByte.pop_front();
        t = expTag.pop_front();
        check(outData == e, t, outData, e);
        frameCnt++;
        if (e == 8'hC0 && expLen.size() > 0) begin
          int l, n;
          l = expLen.pop_front();
          n = expN.pop_front();
          check(frameCnt == l && frameCnt <= 2 * n + 1, "R9 frame length",
                frameCnt[7:0], l[7:0]);
          frameCnt = 0;
        end
      end
    end else if (outValid) begin
      holdPend = 1;
      holdData = outData;
    end
    accepted = inValid && inReady;
    if (accepted && (curEsc || inLast)) chkBlocked = 1;
    @(negedge clk);
  endtask

  task automatic sendByte(logic [1:0] mode, logic last, logic [7:0] raw);
    logic [7:0] key, data, s;
    bit acc, esc;
    key  = mdl[7:0];
    data = (mode == 2'd1) ? (8'hC0 ^ key) : (mode == 2'd2) ? (8'hDB ^ key) : raw;
    s    = data ^ key;
    esc  = (s == 8'hC0) || (s == 8'hDB);
    if (s == 8'hC0) begin
      expByte.push_back(8'hDB); expTag.push_back("R3 lead");
      expByte.push_back(8'hDC); expTag.push_back("R3 tail");
    end else if (s == 8'hDB) begin
      expByte.push_back(8'hDB); expTag.push_back("R4 lead");
      expByte.push_back(8'hDD); expTag.push_back("R4 tail");
    end else begin
      expByte.push_back(s);
      expTag.push_back(firstOfFrame ? "R2 first key" : afterEsc ? "R10 key after escape" : "R5 plain");
    end
    frameLen += esc ? 2 : 1;
    frameN++;
    afterEsc = esc;
    firstOfFrame = 0;
    mdl = step8(mdl);
    if (last) begin
      expByte.push_back(8'hC0); expTag.push_back("R6 delimiter");
      expLen.push_back(frameLen + 1); expN.push_back(frameN);
      frameLen = 0; frameN = 0; firstOfFrame = 1; afterEsc = 0; mdl = SEED;
    end
    curEsc = esc; inValid = 1; inData = data; inLast = last;
    do runCycle(acc); while (!acc);
    inValid = 0; inLast = 0;
  endtask

  task automatic drain();
    bit acc;
    for (int g = 0; g < 200 && expByte.size() > 0; g++) runCycle(acc);
    check(expByte.size() == 0, "R6 drain complete", 8'(expByte.size()), 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!outValid && inReady, "R1 reset idle", {6'd0, outValid, inReady}, 8'h01);
    rstN = 1;
    @(negedge clk);
    #1;
    check(!outValid && inReady, "R1 after release", {6'd0, outValid, inReady}, 8'h01);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) sendByte(VEC[i][10:9], VEC[i][8], VEC[i][7:0]);
    drain();

    // Mid-frame reset: the keystream must restart from the seed.
    sendByte(2'd0, 1'b0, 8'h33);
    sendByte(2'd1, 1'b0, 8'h00);
    drain();
    rstN = 0;
    repeat (2) @(negedge clk);
    #1;
    check(!outValid && inReady, "R1 mid-frame reset", {6'd0, outValid, inReady}, 8'h01);
    rstN = 1;
    mdl = SEED; frameLen = 0; frameN = 0; frameCnt = 0; firstOfFrame = 1; afterEsc = 0;
    holdPend = 0; chkBlocked = 0;
    @(negedge clk);
    sendByte(2'd0, 1'b1, 8'h00);   // expect 0xE1 then 0xC0
    drain();

    summary();
    $finish;
  end
endmodule